// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sequences a device into and out of two stop modes. Shallow stop keeps every register, memory and pin intact. It puts the regulator into standby and turns off the clocks of six peripherals that do nothing while stopped. Deep stop powers down most logic. It holds the powered-down domains in reset and freezes the I/O pin latches. On exit it raises a recovery flag, so that software can tell a return from deep stop apart from a cold start.

Software asks for a stop with a request pulse and a mode select. A short entry sequence follows, and a qualified wakeup during that sequence cancels the request. Wakeups come from six external peripheral lines, each passed through a two-flop synchronizer, and from an always-on real-time-clock (RTC) tick domain. The RTC domain is reset only at power-on. Its pending flag therefore survives both a deep-stop exit and an external reset. An external reset input brings the controller back to run from any state.

After a deep-stop exit the pins stay latched and the flag stays set until software writes 1 to the acknowledge bit. Software is expected to restore the port and peripheral settings before it writes the acknowledge.

Top module: `lpstop_ctrl`

## Requirements
- R1: After reset: run state, every `periph_clk_en` bit 1, and all other outputs 0. A `stop_req` pulse with `stop_deep`=0 raises `reg_stby` exactly ENTRY_CYC (default 3) cycles after the request is sampled. In shallow stop all `periph_clk_en` bits are 0 and `pwr_down` stays 0.
- R2: Any qualified source leaves shallow stop. The exit produces one cycle of `resume` with a one-hot `resume_src` (bit 0 RTC, 1 comparator, 2 ADC, 3 IRQ, 4 SCI, 5 LCD, 6 KBI; `wake_ext` bit k maps to source bit k+1). Clocks are re-enabled, and neither `dom_rst` nor `recov_flag` rises.
- R3: `stop_deep`=1 enters deep stop after the same entry time. `pwr_down`, `dom_rst` and `pin_hold` go to 1 and every clock enable to 0. With the default deep mask only the RTC wakes deep stop, so external wake lines are ignored there.
- R4: A pending RTC flag ends deep stop on the next clock. `pwr_down` falls, and `dom_rst` stays 1 for RST_CYC cycles (at least 2, default 2) after that fall, then drops.
- R5: Leaving deep stop sets `recov_flag` and keeps `pin_hold`. Both clear one cycle after a write of 1 to the acknowledge bit (`ack_wr`=1, `ack_wdata`=1).
- R6: An acknowledge write of 0 changes nothing. An acknowledge while the flag is clear changes nothing. An acknowledge during deep stop is ignored, including one in the same cycle as the waking RTC flag.
- R7: The RTC flag `rtc_pend` sets every RTC_PERIOD (default 300) cycles and stays set until `rtc_clr`. Neither a deep-stop exit nor the external reset disturbs it; only `rst_n` does.
- R8: External wake lines pass two synchronizer flops. A line raised before clock edge 1 produces `resume` after edge 3 and not after edge 2.
- R9: A qualified wakeup during the entry sequence cancels it, even on the last entry cycle. The controller returns to run with no standby, no power-down, no pin hold and no `resume`. This includes a deep request made while the RTC flag is already pending.
- R10: `ext_rst_n` low, after two synchronizer flops, raises `full_rst`. On the next clock the controller is back in run, with `recov_flag`, `pin_hold` and `reg_stby` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| stop_req | input | 1 | Stop request pulse |
| stop_deep | input | 1 | Mode select: 1 deep, 0 shallow |
| wake_ext | input | 6 | Peripheral wake lines: comparator, ADC, IRQ, SCI, LCD, KBI |
| ack_wr | input | 1 | Acknowledge register write strobe |
| ack_wdata | input | 1 | Acknowledge write data |
| rtc_clr | input | 1 | Clears the RTC pending flag |
| pwr_down | output | 1 | Deep stop active |
| dom_rst | output | 1 | Reset to powered-down domains |
| pin_hold | output | 1 | I/O pin latch hold |
| recov_flag | output | 1 | Deep-stop recovery status |
| reg_stby | output | 1 | Regulator standby (shallow stop) |
| periph_clk_en | output | 6 | Clock enables: SPI, IIC, timer A, timer B, delay block, TPM |
| resume | output | 1 | One-cycle pulse on interrupt exit from shallow stop |
| resume_src | output | 7 | Source vector of the last shallow exit |
| full_rst | output | 1 | Synchronized external reset |
| rtc_pend | output | 1 | RTC pending flag |

## Verification
Two pairs of functions can fall in the same cycle. In the first, the bench raises a wake line so that its synchronized copy arrives exactly on the final entry cycle. It then judges that cancellation wins over commit: no standby, no power-down and no resume pulse. In the second, the bench polls for the RTC flag while in deep stop and writes the acknowledge bit in that same cycle. It expects the exit to win, with the recovery flag set and the pins still held. A scoreboard matches each expected resume source against the pulses the design emits and flags any pulse it did not expect.

// File: rtl/lpstop_pkg.sv
`timescale 1ns/1ps
package lpstop_pkg;
    localparam int N_EXT  = 6;          // external wake lines
    localparam int N_SRC  = N_EXT + 1;  // plus the RTC tick, at bit 0
    localparam int N_GATE = 6;          // gated peripheral clocks

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ENTER,
        ST_SHALLOW,
        ST_DEEP,
        ST_EXIT
    } stop_st_e;
endpackage

// File: rtl/lpstop_sync.sv
`timescale 1ns/1ps
module lpstop_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign dout = sy_q.s2;
endmodule

// File: rtl/lpstop_rtc.sv
`timescale 1ns/1ps
module lpstop_rtc #(
    parameter int PERIOD = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic pend
);
    localparam int CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } rtc_t;

    rtc_t rt_d, rt_q;
    logic wrap;

    always_comb begin
        rt_d     = rt_q;
        wrap     = (rt_q.cnt == CW'(PERIOD - 1));
        rt_d.cnt = wrap ? '0 : rt_q.cnt + 1'b1;
        // a new tick outranks a clear in the same cycle
        rt_d.pend = wrap | (rt_q.pend & ~clr);
    end

    // powered only by the always-on domain: cleared by power-on reset alone
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign pend = rt_q.pend;

    assert_pend_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);
endmodule

// File: rtl/lpstop_seq.sv
`timescale 1ns/1ps
module lpstop_seq
    import lpstop_pkg::*;
#(
    parameter int               ENTRY_CYC = 3,
    parameter int               RST_CYC   = 2,
    parameter logic [N_SRC-1:0] DEEP_MASK = N_SRC'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst,
    input  logic              stop_req,
    input  logic              stop_deep,
    input  logic [N_SRC-1:0]  wake_vec,
    input  logic              ack_wr,
    input  logic              ack_wdata,
    output logic              pwr_down,
    output logic              dom_rst,
    output logic              pin_hold,
    output logic              recov_flag,
    output logic              reg_stby,
    output logic [N_GATE-1:0] periph_clk_en,
    output logic              resume,
    output logic [N_SRC-1:0]  resume_src
);
    localparam int ENT_LEN = (ENTRY_CYC < 1) ? 1 : ENTRY_CYC;
    localparam int RST_LEN = (RST_CYC < 2) ? 2 : RST_CYC;
    localparam int MAXC    = (ENT_LEN > RST_LEN) ? ENT_LEN : RST_LEN;
    localparam int CNT_W   = $clog2(MAXC + 1);

    typedef struct packed {
        stop_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic              deep_sel;
        logic              hold;
        logic              recov;
        logic              resume;
        logic [N_SRC-1:0]  src;
    } seq_t;

    localparam seq_t SEQ_IDLE = '{st: ST_RUN, cnt: '0, deep_sel: 1'b0, hold: 1'b0,
                                  recov: 1'b0, resume: 1'b0, src: '0};

    seq_t             sq_d, sq_q;
    logic [N_SRC-1:0] elig;
    logic [N_SRC-1:0] qual;
    logic             wake_hit;

    always_comb begin
        sq_d        = sq_q;
        sq_d.resume = 1'b0;
        elig        = sq_q.deep_sel ? DEEP_MASK : '1;
        qual        = wake_vec & elig;
        wake_hit    = |qual;

        // the acknowledge opens the latches, but not while the device sleeps deep
        if (ack_wr && ack_wdata && sq_q.st != ST_DEEP) begin
            sq_d.hold  = 1'b0;
            sq_d.recov = 1'b0;
        end

        unique case (sq_q.st)
            ST_RUN: begin
                if (stop_req) begin
                    sq_d.st       = ST_ENTER;
                    sq_d.cnt      = CNT_W'(ENT_LEN - 1);
                    sq_d.deep_sel = stop_deep;
                end
            end
            ST_ENTER: begin
                if (wake_hit) begin
                    sq_d.st = ST_RUN;              // cancel wins over commit
                end else if (sq_q.cnt == '0) begin
                    if (sq_q.deep_sel) begin
                        sq_d.st   = ST_DEEP;
                        sq_d.hold = 1'b1;
                    end else begin
                        sq_d.st = ST_SHALLOW;
                    end
                end else begin
                    sq_d.cnt = sq_q.cnt - 1'b1;
                end
            end
            ST_SHALLOW: begin
                if (wake_hit) begin
                    sq_d.st     = ST_RUN;
                    sq_d.resume = 1'b1;
                    sq_d.src    = qual;
                end
            end
            ST_DEEP: begin
                if (wake_hit) begin
                    sq_d.st    = ST_EXIT;
                    sq_d.cnt   = CNT_W'(RST_LEN - 1);
                    sq_d.recov = 1'b1;
                end
            end
            ST_EXIT: begin
                if (sq_q.cnt == '0) sq_d.st  = ST_RUN;
                else                sq_d.cnt = sq_q.cnt - 1'b1;
            end
            default: sq_d = SEQ_IDLE;
        endcase

        if (ext_rst) sq_d = SEQ_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= SEQ_IDLE;
        else        sq_q <= sq_d;
    end

    assign pwr_down      = (sq_q.st == ST_DEEP);
    assign dom_rst       = (sq_q.st == ST_DEEP) || (sq_q.st == ST_EXIT);
    assign reg_stby      = (sq_q.st == ST_SHALLOW);
    assign periph_clk_en = ((sq_q.st == ST_SHALLOW) || (sq_q.st == ST_DEEP)) ? '0 : '1;
    assign pin_hold      = sq_q.hold;
    assign recov_flag    = sq_q.recov;
    assign resume        = sq_q.resume;
    assign resume_src    = sq_q.src;

    assert_resume_from_shallow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> $past(reg_stby));

    assert_exit_rst_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down) |-> dom_rst);

    assert_exit_rst_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwr_down) && !ext_rst) |=> dom_rst);

    assert_flag_needs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recov_flag |-> pin_hold);

    assert_ack_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (recov_flag && ack_wr && !ack_wdata && !ext_rst) |=> recov_flag);

    assert_entry_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == ST_ENTER && wake_hit) |=> (!pwr_down && !reg_stby && !resume));
endmodule

// File: rtl/lpstop_ctrl.sv
`timescale 1ns/1ps
module lpstop_ctrl
    import lpstop_pkg::*;
#(
    parameter int               ENTRY_CYC  = 3,
    parameter int               RST_CYC    = 2,
    parameter int               RTC_PERIOD = 300,
    parameter logic [N_SRC-1:0] DEEP_MASK  = N_SRC'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_n,
    input  logic              stop_req,
    input  logic              stop_deep,
    input  logic [N_EXT-1:0]  wake_ext,
    input  logic              ack_wr,
    input  logic              ack_wdata,
    input  logic              rtc_clr,
    output logic              pwr_down,
    output logic              dom_rst,
    output logic              pin_hold,
    output logic              recov_flag,
    output logic              reg_stby,
    output logic [N_GATE-1:0] periph_clk_en,
    output logic              resume,
    output logic [N_SRC-1:0]  resume_src,
    output logic              full_rst,
    output logic              rtc_pend
);
    logic [N_EXT-1:0] wake_s;
    logic             xrst_s;
    logic [N_SRC-1:0] wake_vec;

    lpstop_sync #(.W(N_EXT)) u_wake_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (wake_ext),
        .dout (wake_s)
    );

    lpstop_sync #(.W(1)) u_xrst_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (~ext_rst_n),
        .dout (xrst_s)
    );

    lpstop_rtc #(.PERIOD(RTC_PERIOD)) u_rtc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rtc_clr),
        .pend (rtc_pend)
    );

    // RTC tick already runs on clk, so it enters unsynchronized at bit 0
    assign wake_vec = {wake_s, rtc_pend};
    assign full_rst = xrst_s;

    lpstop_seq #(
        .ENTRY_CYC(ENTRY_CYC),
        .RST_CYC  (RST_CYC),
        .DEEP_MASK(DEEP_MASK)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_rst      (xrst_s),
        .stop_req     (stop_req),
        .stop_deep    (stop_deep),
        .wake_vec     (wake_vec),
        .ack_wr       (ack_wr),
        .ack_wdata    (ack_wdata),
        .pwr_down     (pwr_down),
        .dom_rst      (dom_rst),
        .pin_hold     (pin_hold),
        .recov_flag   (recov_flag),
        .reg_stby     (reg_stby),
        .periph_clk_en(periph_clk_en),
        .resume       (resume),
        .resume_src   (resume_src)
    );

    assert_xrst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        full_rst |=> (!recov_flag && !pin_hold && !reg_stby));
endmodule

// File: tb/lpstop_ctrl_tb.sv
`timescale 1ns/1ps
module lpstop_ctrl_tb;
    import lpstop_pkg::*;

    localparam int ENTRY = 3;
    localparam int RSTC  = 2;
    localparam int PER   = 300;

    logic              clk = 1'b0;
    logic              rst_n, ext_rst_n, stop_req, stop_deep;
    logic [N_EXT-1:0]  wake_ext;
    logic              ack_wr, ack_wdata, rtc_clr;
    logic              pwr_down, dom_rst, pin_hold, recov_flag, reg_stby;
    logic [N_GATE-1:0] periph_clk_en;
    logic              resume, full_rst, rtc_pend;
    logic [N_SRC-1:0]  resume_src;

    always #2.5 clk = ~clk;

    lpstop_ctrl #(.ENTRY_CYC(ENTRY), .RST_CYC(RSTC), .RTC_PERIOD(PER)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .stop_req(stop_req),
        .stop_deep(stop_deep), .wake_ext(wake_ext), .ack_wr(ack_wr),
        .ack_wdata(ack_wdata), .rtc_clr(rtc_clr), .pwr_down(pwr_down),
        .dom_rst(dom_rst), .pin_hold(pin_hold), .recov_flag(recov_flag),
        .reg_stby(reg_stby), .periph_clk_en(periph_clk_en), .resume(resume),
        .resume_src(resume_src), .full_rst(full_rst), .rtc_pend(rtc_pend)
    );

    int               n_chk  = 0;
    int               n_fail = 0;
    logic [N_SRC-1:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor: every resume pulse must match the oldest expectation
    always @(negedge clk) begin
        if (rst_n && resume) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected resume", int'(resume_src), 0);
            end else begin
                logic [N_SRC-1:0] e;
                e = exp_q.pop_front();
                chk(resume_src == e, "R2", "resume source", int'(resume_src), int'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic request(input bit deep);
        stop_deep = deep;
        stop_req  = 1'b1;
        tick();
        stop_req  = 1'b0;
    endtask

    task automatic rtc_clear();
        rtc_clr = 1'b1;
        tick();
        rtc_clr = 1'b0;
    endtask

    task automatic wait_pend(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < PER + 20; i++) begin
            if (rtc_pend) begin seen = 1'b1; break; end
            tick();
        end
    endtask

    task automatic shallow_in();
        request(1'b0);
        tick(ENTRY - 1);
        chk(!reg_stby, "R1", "standby before entry time", reg_stby, 0);
        tick();
        chk(reg_stby, "R1", "standby at entry time", reg_stby, 1);
        chk(periph_clk_en == '0, "R1", "clocks gated", periph_clk_en, 0);
        chk(!pwr_down, "R1", "no power down in shallow", pwr_down, 0);
    endtask

    task automatic ack(input bit v);
        ack_wr    = 1'b1;
        ack_wdata = v;
        tick();
        ack_wr    = 1'b0;
        ack_wdata = 1'b0;
    endtask

    task automatic xrst_pulse();
        bit seen;
        ext_rst_n = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (full_rst) begin seen = 1'b1; break; end
        end
        chk(seen, "R10", "full reset raised", seen, 1);
        tick();
    endtask

    task automatic xrst_release();
        ext_rst_n = 1'b1;
        for (int i = 0; i < 10 && full_rst; i++) tick();
        tick(2);
    endtask

    initial begin
        bit seen;
        int n;
        rst_n = 1'b0; ext_rst_n = 1'b1; stop_req = 1'b0; stop_deep = 1'b0;
        wake_ext = '0; ack_wr = 1'b0; ack_wdata = 1'b0; rtc_clr = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick();

        // reset state (R1)
        chk(!pwr_down && !dom_rst && !pin_hold && !recov_flag, "R1", "reset state flags",
            {pwr_down, dom_rst, pin_hold, recov_flag}, 0);
        chk(!reg_stby && !resume && !full_rst, "R1", "reset state misc",
            {reg_stby, resume, full_rst}, 0);
        chk(periph_clk_en == '1, "R1", "reset clocks on", periph_clk_en, 6'h3f);

        // R7: RTC tick period
        wait_pend(seen);
        chk(seen, "R7", "first RTC tick", seen, 1);
        rtc_clr = 1'b1;
        n = 0;
        do begin
            tick();
            rtc_clr = 1'b0;
            n++;
        end while (!rtc_pend && n < PER + 20);
        chk(n == PER, "R7", "RTC period", n, PER);
        rtc_clear();

        // R1, R2, R8: shallow stop woken by each external line
        for (int k = 0; k < N_EXT; k++) begin
            shallow_in();
            wake_ext[k] = 1'b1;
            exp_q.push_back(N_SRC'(1) << (k + 1));
            tick(2);
            chk(!resume, "R8", "no resume after two edges", resume, 0);
            tick();
            chk(resume, "R8", "resume after third edge", resume, 1);
            chk(periph_clk_en == '1, "R2", "clocks back on", periph_clk_en, 6'h3f);
            chk(!dom_rst && !recov_flag, "R2", "no reset or flag on shallow exit",
                {dom_rst, recov_flag}, 0);
            wake_ext = '0;
            tick();
            chk(!resume, "R2", "resume lasts one cycle", resume, 0);
            tick(3);
        end

        // R9: wake lands on the final entry cycle
        request(1'b0);
        wake_ext[3] = 1'b1;
        tick(ENTRY);
        chk(!reg_stby && !pwr_down, "R9", "entry cancelled", {reg_stby, pwr_down}, 0);
        chk(periph_clk_en == '1, "R9", "clocks stay on", periph_clk_en, 6'h3f);
        wake_ext = '0;
        tick(4);
        chk(!reg_stby, "R9", "still running", reg_stby, 0);

        // R2, R7: RTC tick wakes shallow stop, flag survives
        shallow_in();
        exp_q.push_back(N_SRC'(1));
        seen = 1'b0;
        for (int i = 0; i < PER + 20; i++) begin
            tick();
            if (resume) begin seen = 1'b1; break; end
        end
        chk(seen, "R2", "RTC wake of shallow stop", seen, 1);
        chk(rtc_pend, "R7", "RTC flag kept after shallow wake", rtc_pend, 1);

        // R9: deep request with the RTC flag already pending
        request(1'b1);
        tick(ENTRY);
        chk(!pwr_down && !pin_hold && !dom_rst, "R9", "deep entry cancelled",
            {pwr_down, pin_hold, dom_rst}, 0);
        rtc_clear();

        // R3: deep entry
        request(1'b1);
        tick(ENTRY - 1);
        chk(!pwr_down, "R3", "no power down before entry time", pwr_down, 0);
        tick();
        chk(pwr_down && dom_rst && pin_hold, "R3", "deep outputs",
            {pwr_down, dom_rst, pin_hold}, 7);
        chk(periph_clk_en == '0 && !reg_stby, "R3", "clocks off, no standby",
            {periph_clk_en, reg_stby}, 0);
        wake_ext[2] = 1'b1;
        tick(5);
        wake_ext = '0;
        chk(pwr_down, "R3", "external wake ignored in deep", pwr_down, 1);
        ack(1'b1);
        chk(pin_hold && pwr_down, "R6", "ack ignored in deep", {pin_hold, pwr_down}, 3);

        // R4, R5, R6: RTC wake, acknowledge in the same cycle
        seen = 1'b0;
        for (int i = 0; i < PER + 20; i++) begin
            tick();
            if (rtc_pend) begin seen = 1'b1; break; end
        end
        chk(seen && pwr_down, "R4", "deep still active when flag rises", {seen, pwr_down}, 3);
        ack(1'b1);
        chk(!pwr_down && dom_rst, "R4", "exit: power up, domain reset",
            {pwr_down, dom_rst}, 1);
        chk(recov_flag && pin_hold, "R5", "flag set, pins held despite ack",
            {recov_flag, pin_hold}, 3);
        chk(rtc_pend, "R7", "RTC flag kept across deep exit", rtc_pend, 1);
        tick();
        chk(dom_rst, "R4", "domain reset second cycle", dom_rst, 1);
        tick();
        chk(!dom_rst, "R4", "domain reset released", dom_rst, 0);
        chk(recov_flag && pin_hold, "R5", "flag and hold persist", {recov_flag, pin_hold}, 3);
        ack(1'b0);
        chk(recov_flag && pin_hold, "R6", "ack of zero no effect", {recov_flag, pin_hold}, 3);
        tick();
        chk(recov_flag && pin_hold, "R6", "ack of zero still no effect",
            {recov_flag, pin_hold}, 3);
        ack(1'b1);
        chk(!recov_flag && !pin_hold, "R5", "ack clears flag and hold",
            {recov_flag, pin_hold}, 0);
        ack(1'b1);
        chk(!recov_flag && !pin_hold && !pwr_down, "R6", "repeat ack harmless",
            {recov_flag, pin_hold, pwr_down}, 0);
        chk(periph_clk_en == '1, "R6", "clocks on after repeat ack", periph_clk_en, 6'h3f);
        rtc_clear();

        // R10: external reset during shallow stop
        shallow_in();
        xrst_pulse();
        chk(!reg_stby && periph_clk_en == '1, "R10", "shallow left by reset",
            {reg_stby, periph_clk_en}, 6'h3f);
        xrst_release();

        // R10, R7: external reset after a deep exit
        request(1'b1);
        tick(ENTRY);
        chk(pwr_down, "R3", "second deep entry", pwr_down, 1);
        for (int i = 0; i < PER + 20 && pwr_down; i++) tick();
        tick(RSTC + 1);
        chk(recov_flag && pin_hold, "R5", "second exit flag", {recov_flag, pin_hold}, 3);
        xrst_pulse();
        chk(!recov_flag && !pin_hold, "R10", "reset clears flag and hold",
            {recov_flag, pin_hold}, 0);
        chk(rtc_pend, "R7", "RTC flag survives external reset", rtc_pend, 1);
        xrst_release();

        chk(exp_q.size() == 0, "R2", "all expected resumes seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule